// File: doc/BRIEF.md
# Two-Stage SCL Rate Prescaler

This block produces the timing ticks that pace an I2C master's clock line. The system clock goes through two cascaded programmable dividers: a coarse stage with a 2-bit setting and a fine stage with a 6-bit setting. A modulo-22 phase counter then splits each SCL period into a low half and a high half of 11 ticks each. The resulting SCL frequency is fclk / (22 × (A+1) × (B+1)). Software chooses the two settings for the bus rate it wants. Standard bus rates stay at or below 400 kHz, and the product (A+1)(B+1) is at most 256.

The transfer engine uses the per-tick pulse, the end-of-period strobe and the half indicator to time START, data bits and STOP. The divisor inputs are copied into internal registers only while the engine reports that it is idle, so a bit period that is already running is never shortened. When the engine has released SCL but the line still reads low, a target is stretching the clock. In that case the ticks are withheld and the phase position is held until the line rises.

Top module: `scl_prescaler`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) with enable low, phase_tick and period_strobe are 0 and scl_high_phase is 0. The latched divisors are both 0.
- R2: The coarse stage pulses once every (A+1) clocks, where A is the 2-bit div_a value, so A=0..3 gives a factor of 1..4.
- R3: While enabled and not stalled, phase_tick is high for one clock every (A+1)×(B+1) clocks, where B is the 6-bit div_b value (B+1 from 1 to 64).
- R4: period_strobe is high only together with phase_tick, on every 22nd phase tick, so consecutive strobes are 22×(A+1)×(B+1) clocks apart.
- R5: The phase position counts 0..21 and advances on each phase_tick. scl_high_phase is 0 at positions 0..10 and 1 at positions 11..21.
- R6: div_a and div_b are latched on a clock edge only when busy is 0. Values presented while busy is 1 do not change the tick spacing.
- R7: While scl_release is 1 and scl_in is 0, phase_tick and period_strobe stay 0 and the phase position does not change.
- R8: While enable is 0, no ticks or strobes are emitted and every counter returns to zero. After enable rises, counting restarts from phase position 0.
- R9: At the largest setting (A=3, B=63), strobes are 5632 clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the dividers; 0 clears all counters |
| busy | input | 1 | Engine active; divisor inputs are ignored while 1 |
| div_a | input | 2 | Coarse divisor setting A (factor A+1) |
| div_b | input | 6 | Fine divisor setting B (factor B+1) |
| scl_release | input | 1 | Engine is releasing SCL high |
| scl_in | input | 1 | Sampled level of the SCL line |
| phase_tick | output | 1 | One-clock tick, 22 per SCL period |
| period_strobe | output | 1 | One-clock strobe on the last tick of each SCL period |
| scl_high_phase | output | 1 | 1 during the high half of the SCL period |

## Verification
The assertions check on every cycle that a strobe never appears without a tick, and that enable low or a stretch suppresses ticks. They also check that the phase position stays below 22 and is frozen between ticks, and that the latched divisors do not move while the engine is busy. Only the bench's scenarios can show the actual spacing of ticks and strobes for each divisor setting. The same holds for rejecting a divisor change made while busy, for the restart from zero after enable drops, and for the largest-setting period. A behavioural model compares phase_tick, period_strobe and scl_high_phase with the design on every clock.

// File: rtl/scl_presc_pkg.sv
// Shared constants for the SCL prescaler.
// Assumes the phase count is even so the two halves are equal.
package scl_presc_pkg;
    localparam int PHASES    = 22;
    localparam int HALF      = PHASES / 2;
    localparam int PHASE_W   = $clog2(PHASES);
    typedef logic [PHASE_W-1:0] phase_t;
endpackage

// File: rtl/scl_stage_div.sv
// Programmable pulse divider: emits one output pulse per (limit+1) input pulses.
// Assumes limit may change between pulses; a count at or above the limit wraps at once.
module scl_stage_div #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         in_pulse,
    input  logic [W-1:0] limit,
    output logic         out_pulse
);
    logic [W-1:0] cnt;

    // Output fires on the input pulse that completes a group.
    always_comb begin
        out_pulse = en && in_pulse && (cnt >= limit);
    end

    // Count input pulses, clearing on reset, disable or group end.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (in_pulse) begin
            cnt <= out_pulse ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/scl_phase_ctr.sv
// Modulo-PHASES position counter splitting an SCL period into low and high halves.
// Assumes adv is a single-clock pulse already gated by enable and stretch.
module scl_phase_ctr
    import scl_presc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   en,
    input  logic   adv,
    output phase_t pos,
    output logic   wrap,
    output logic   high_half
);
    localparam phase_t LAST = phase_t'(PHASES - 1);

    // Strobe on the tick that ends the period; half flag from position.
    always_comb begin
        wrap      = adv && (pos == LAST);
        high_half = (pos >= phase_t'(HALF));
    end

    // Advance position per tick, wrapping after the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pos <= '0;
        end else if (adv) begin
            pos <= wrap ? '0 : pos + 1'b1;
        end
    end

    // R5
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos < phase_t'(PHASES));

    // R7
    pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !adv) |=> $stable(pos));
endmodule

// File: rtl/scl_prescaler.sv
// Top of the SCL prescaler: latches divisors while idle, cascades the coarse and
// fine stages, suppresses ticks during clock stretching and tracks the phase.
// Assumes scl_in is already synchronised to clk.
module scl_prescaler
    import scl_presc_pkg::*;
#(
    parameter int A_W = 2,
    parameter int B_W = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic           busy,
    input  logic [A_W-1:0] div_a,
    input  logic [B_W-1:0] div_b,
    input  logic           scl_release,
    input  logic           scl_in,
    output logic           phase_tick,
    output logic           period_strobe,
    output logic           scl_high_phase
);
    logic [A_W-1:0] a_q;
    logic [B_W-1:0] b_q;
    logic           tick_a;
    logic           tick_b;
    logic           stall;
    phase_t         pos;

    // Capture divisor settings only while the engine is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (!busy) begin
            a_q <= div_a;
            b_q <= div_b;
        end
    end

    scl_stage_div #(.W(A_W)) u_stage_a (
        .clk(clk), .rst_n(rst_n), .en(enable), .in_pulse(1'b1),
        .limit(a_q), .out_pulse(tick_a)
    );

    scl_stage_div #(.W(B_W)) u_stage_b (
        .clk(clk), .rst_n(rst_n), .en(enable), .in_pulse(tick_a),
        .limit(b_q), .out_pulse(tick_b)
    );

    // A stretch is the line held low after the engine has let it go.
    always_comb begin
        stall      = scl_release && !scl_in;
        phase_tick = tick_b && !stall;
    end

    scl_phase_ctr u_phase (
        .clk(clk), .rst_n(rst_n), .en(enable), .adv(phase_tick),
        .pos(pos), .wrap(period_strobe), .high_half(scl_high_phase)
    );

    // R4
    strobe_with_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_strobe |-> phase_tick);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!phase_tick && !period_strobe));

    // R7
    stretch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_release && !scl_in) |-> !phase_tick);

    // R6
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(a_q) && $stable(b_q)));
endmodule

// File: tb/scl_prescaler_test.sv
module scl_prescaler_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       busy = 1'b0;
    logic [1:0] div_a = '0;
    logic [5:0] div_b = '0;
    logic       scl_release = 1'b0;
    logic       scl_in = 1'b1;
    logic       phase_tick, period_strobe, scl_high_phase;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    scl_prescaler uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .busy(busy),
        .div_a(div_a), .div_b(div_b), .scl_release(scl_release),
        .scl_in(scl_in), .phase_tick(phase_tick),
        .period_strobe(period_strobe), .scl_high_phase(scl_high_phase)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: clock counts since the last tick and tick counts in the period.
    int m_la = 0, m_lb = 0, m_clk = 0, m_sub = 0, m_ph = 0;
    bit model_on = 0;
    always @(negedge clk) begin
        bit ta, tb, pt, ps;
        if (model_on) begin
            ta = enable && (m_clk >= m_la);
            tb = ta && (m_sub >= m_lb);
            pt = tb && !(scl_release && !scl_in);
            ps = pt && (m_ph == 21);
            chk("R3 phase_tick", phase_tick, pt);
            chk("R4 period_strobe", period_strobe, ps);
            chk("R5 scl_high_phase", scl_high_phase, (m_ph >= 11));
            if (!rst_n) begin
                m_la = 0; m_lb = 0; m_clk = 0; m_sub = 0; m_ph = 0;
            end else begin
                if (!enable) begin
                    m_clk = 0; m_sub = 0; m_ph = 0;
                end else begin
                    m_clk = ta ? 0 : m_clk + 1;
                    if (ta) m_sub = tb ? 0 : m_sub + 1;
                    if (pt) m_ph = (m_ph == 21) ? 0 : m_ph + 1;
                end
                if (!busy) begin
                    m_la = div_a; m_lb = div_b;
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Clocks between two consecutive strobes.
    task automatic gap(output int n);
        n = 0;
        while (!period_strobe) @(negedge clk);
        @(negedge clk);
        n = 1;
        while (!period_strobe) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #1600000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int g;
        int cnt;
        step(3);
        @(negedge clk);
        // R1 reset state
        chk("R1 tick after reset", phase_tick, 0);
        chk("R1 strobe after reset", period_strobe, 0);
        chk("R1 half after reset", scl_high_phase, 0);
        step(1);
        rst_n = 1'b1;
        model_on = 1;
        step(2);
        // R1 latched divisors are zero: first period takes 22 clocks
        enable = 1'b1;
        gap(g); chk("R1 period with zero divisors", g, 22);
        // R2 coarse stage only
        enable = 1'b0; div_a = 2'd2; div_b = 6'd0; step(2);
        enable = 1'b1; gap(g); chk("R2 coarse factor 3", g, 66);
        // R3 combined
        enable = 1'b0; div_a = 2'd1; div_b = 6'd4; step(2);
        enable = 1'b1; gap(g); chk("R3 combined factor 10", g, 220);
        gap(g); chk("R4 strobe spacing", g, 220);
        // R6 change while busy ignored
        step(1); busy = 1'b1; step(1);
        div_a = 2'd3; div_b = 6'd9; step(1);
        gap(g); chk("R6 busy keeps old spacing", g, 220);
        gap(g); chk("R6 busy keeps old spacing again", g, 220);
        busy = 1'b0; enable = 1'b0; step(2);
        div_a = 2'd0; div_b = 6'd1; step(2);
        enable = 1'b1; gap(g); chk("R6 idle takes new setting", g, 44);
        // R7 stretch
        step(5);
        scl_release = 1'b1; scl_in = 1'b0;
        cnt = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (phase_tick || period_strobe) cnt++;
        end
        chk("R7 no ticks while stretched", cnt, 0);
        step(1); scl_in = 1'b1; scl_release = 1'b0;
        gap(g); chk("R7 normal after release", g, 44);
        // R8 disable
        step(3); enable = 1'b0;
        cnt = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (phase_tick || period_strobe || scl_high_phase) cnt++;
        end
        chk("R8 quiet while disabled", cnt, 0);
        step(1); enable = 1'b1;
        // first strobe after restart comes after a full period
        cnt = 0;
        @(negedge clk);
        cnt = 1;
        while (!period_strobe) begin @(negedge clk); cnt++; end
        chk("R8 restart from zero", cnt, 44);
        // R9 maximum
        enable = 1'b0; div_a = 2'd3; div_b = 6'd63; step(2);
        enable = 1'b1; gap(g); chk("R9 max period", g, 5632);
        step(2);
        model_on = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule